// File: doc/BRIEF.md
# Frequency-Directed Run-Length Decoder

This block expands compressed scan stimulus into the bit stream that feeds a scan chain. Each code word is taken one bit per cycle from a serial input. It names a run of equal bits plus a closing bit of the opposite value, and the block plays that pattern out one bit per cycle on a serial output.

A code word has two parts, a prefix and a tail. The prefix is a string of ones closed by a zero. Its length k, counted with the closing zero, picks a group. The group holds 2^k run lengths, and the tail of k bits picks one of them. Short runs occur most often, so they get the shortest code words.

When the extended-mode input is high at the start of a code word, one polarity bit comes before the prefix:
- A polarity of 0 selects a run of zeros closed by a one.
- A polarity of 1 selects a run of ones closed by a zero.

A sideband flag on the last tail bit marks the final symbol of the data. That symbol is played without its closing bit. Both sides use valid/ready handshakes. The input is held off while a run is being played out. A prefix that is too long for the configured number of groups stops the block with a sticky error.

Top module: `fdr_run_decoder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err is 0.
- R2: The prefix is the number of leading ones plus the closing zero, giving k. The next k input bits form the tail, most significant bit first. The run length is L = 2^k - 2 + tail. For example, code word 00 gives L=0, 1000 gives L=2 and 1010 gives L=4.
- R3: With extended mode low, a code word produces L zeros followed by a single one.
- R4: With extended mode high, the first bit of the code word is the polarity. Polarity 0 produces L zeros then a one. Polarity 1 produces L ones then a zero.
- R5: If in_last is 1 while the final tail bit is accepted, the closing bit is left out. Only the L run bits are produced, so L=0 produces nothing.
- R6: A prefix of MAX_GROUP ones sets err. err then stays 1, with in_ready 0 and out_valid 0, until reset.
- R7: One output bit moves per cycle in which out_valid and out_ready are both 1. While out_ready is 0, out_valid stays 1 and out_bit holds its value.
- R8: From the acceptance of a code word's final tail bit until its last output bit has been taken, in_ready is 0. In particular, in_ready is 0 whenever out_valid is 1.
- R9: ext_mode is sampled at the first bit of each code word, so the mode may change between code words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = each code word starts with a polarity bit |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Serial code bit |
| in_last | input | 1 | With the final tail bit: leave out the closing bit |
| in_ready | output | 1 | Decoder accepts an input bit |
| out_valid | output | 1 | Output bit is valid |
| out_bit | output | 1 | Serial decoded scan bit |
| out_ready | input | 1 | Consumer takes the output bit |
| err | output | 1 | Sticky prefix-overlength error |

## Verification
The checker watches four behaviours on every cycle:
- the output bit stays stable under back-pressure;
- the input is stalled whenever output is pending;
- the error flag is sticky;
- the block is silent once in error.

The run lengths, the run polarity, the closing bit, the effect of the last flag and the switching of mode between code words can only be shown by the bench. It drives encoded code words and compares the whole expanded stream, including a group at the maximum size and runs taken under random back-pressure.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
   typedef enum logic [1:0] {
      PS_START  = 2'd0,
      PS_PREFIX = 2'd1,
      PS_TAIL   = 2'd2,
      PS_ERR    = 2'd3
   } parse_state_e;
endpackage

// File: rtl/fdr_cw_parser.sv
module fdr_cw_parser
   import fdr_pkg::*;
#(
   parameter int MAX_GROUP      = 8,
   parameter bit TAIL_MSB_FIRST = 1'b1,
   localparam int CNT_W         = $clog2(MAX_GROUP + 1),
   localparam int LEN_W         = MAX_GROUP + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_mode,
   input  logic             take,
   input  logic             in_bit,
   input  logic             in_last,
   output logic             can_accept,
   output logic             cw_load,
   output logic [LEN_W-1:0] cw_len,
   output logic             cw_val,
   output logic             cw_follow,
   output logic             err
);
   parse_state_e           state_q, state_d;
   logic [CNT_W-1:0]       ones_q, ones_d, ones_cur;
   logic [CNT_W-1:0]       k_q, k_d, left_q, left_d;
   logic [MAX_GROUP-1:0]   tail_q, tail_d, tail_next;
   logic                   typ_q, typ_d;
   logic                   load_d;
   logic [LEN_W-1:0]       len_d;
   logic                   follow_d;
   logic [LEN_W-1:0]       group_base;
   logic                   prefix_bit;

   // tail assembly variant
   generate
      if (TAIL_MSB_FIRST) begin : g_tail_msb
         assign tail_next = {tail_q[MAX_GROUP-2:0], in_bit};
      end else begin : g_tail_lsb
         logic [CNT_W-1:0] pos;
         assign pos       = k_q - left_q;
         assign tail_next = tail_q | (MAX_GROUP'(in_bit) << pos);
      end
   endgenerate

   assign ones_cur   = (state_q == PS_START) ? '0 : ones_q;
   assign group_base = (LEN_W'(1) << k_q) - LEN_W'(2);
   assign prefix_bit = (state_q == PS_PREFIX) || (state_q == PS_START && !ext_mode);

   always_comb begin
      state_d  = state_q;
      ones_d   = ones_q;
      k_d      = k_q;
      left_d   = left_q;
      tail_d   = tail_q;
      typ_d    = typ_q;
      load_d   = 1'b0;
      len_d    = cw_len;
      follow_d = cw_follow;
      if (take) begin
         if (state_q == PS_START) begin
            ones_d = '0;
            typ_d  = ext_mode ? in_bit : 1'b0;
            if (ext_mode) state_d = PS_PREFIX;
         end
         if (prefix_bit) begin
            if (in_bit) begin
               if (ones_cur == CNT_W'(MAX_GROUP - 1)) begin
                  state_d = PS_ERR;
               end else begin
                  ones_d  = ones_cur + CNT_W'(1);
                  state_d = PS_PREFIX;
               end
            end else begin
               k_d     = ones_cur + CNT_W'(1);
               left_d  = ones_cur + CNT_W'(1);
               tail_d  = '0;
               state_d = PS_TAIL;
            end
         end else if (state_q == PS_TAIL) begin
            tail_d = tail_next;
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
               load_d   = 1'b1;
               len_d    = group_base + LEN_W'(tail_next);
               follow_d = !in_last;
               state_d  = PS_START;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= PS_START;
         ones_q    <= '0;
         k_q       <= '0;
         left_q    <= '0;
         tail_q    <= '0;
         typ_q     <= 1'b0;
         cw_load   <= 1'b0;
         cw_len    <= '0;
         cw_val    <= 1'b0;
         cw_follow <= 1'b0;
      end else begin
         state_q   <= state_d;
         ones_q    <= ones_d;
         k_q       <= k_d;
         left_q    <= left_d;
         tail_q    <= tail_d;
         typ_q     <= typ_d;
         cw_load   <= load_d;
         cw_len    <= len_d;
         cw_follow <= follow_d;
         if (load_d) cw_val <= typ_q;
      end
   end

   assign can_accept = (state_q != PS_ERR) && !cw_load;
   assign err        = (state_q == PS_ERR);
endmodule

// File: rtl/fdr_run_emitter.sv
module fdr_run_emitter #(
   parameter int LEN_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cw_load,
   input  logic [LEN_W-1:0] cw_len,
   input  logic             cw_val,
   input  logic             cw_follow,
   input  logic             out_ready,
   output logic             out_valid,
   output logic             out_bit,
   output logic             busy
);
   logic [LEN_W-1:0] rem_q;
   logic             val_q;
   logic             fol_q;
   logic             in_run;

   assign in_run    = (rem_q != '0);
   assign busy      = in_run || fol_q;
   assign out_valid = busy;
   assign out_bit   = in_run ? val_q : ~val_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q <= '0;
         val_q <= 1'b0;
         fol_q <= 1'b0;
      end else if (cw_load) begin
         rem_q <= cw_len;
         val_q <= cw_val;
         fol_q <= cw_follow;
      end else if (busy && out_ready) begin
         if (in_run) rem_q <= rem_q - LEN_W'(1);
         else        fol_q <= 1'b0;
      end
   end
endmodule

// File: rtl/fdr_run_decoder.sv
module fdr_run_decoder #(
   parameter int MAX_GROUP      = 8,
   parameter bit TAIL_MSB_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_mode,
   input  logic in_valid,
   input  logic in_bit,
   input  logic in_last,
   output logic in_ready,
   output logic out_valid,
   output logic out_bit,
   input  logic out_ready,
   output logic err
);
   localparam int LEN_W = MAX_GROUP + 1;

   generate
      if (MAX_GROUP < 2 || MAX_GROUP > 30) begin : g_bad_cfg
         $error("MAX_GROUP must lie in 2..30");
      end
   endgenerate

   logic             can_accept, take, busy;
   logic             cw_load, cw_val, cw_follow;
   logic [LEN_W-1:0] cw_len;

   assign in_ready = can_accept && !busy;
   assign take     = in_valid && in_ready;

   fdr_cw_parser #(
      .MAX_GROUP(MAX_GROUP),
      .TAIL_MSB_FIRST(TAIL_MSB_FIRST)
   ) parser_i (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .take(take),
      .in_bit(in_bit), .in_last(in_last), .can_accept(can_accept),
      .cw_load(cw_load), .cw_len(cw_len), .cw_val(cw_val),
      .cw_follow(cw_follow), .err(err)
   );

   fdr_run_emitter #(
      .LEN_W(LEN_W)
   ) emitter_i (
      .clk(clk), .rst_n(rst_n), .cw_load(cw_load), .cw_len(cw_len),
      .cw_val(cw_val), .cw_follow(cw_follow), .out_ready(out_ready),
      .out_valid(out_valid), .out_bit(out_bit), .busy(busy)
   );
endmodule

// File: rtl/fdr_run_decoder_chk.sv
module fdr_run_decoder_chk (
   input logic clk,
   input logic rst_n,
   input logic in_ready,
   input logic out_valid,
   input logic out_bit,
   input logic out_ready,
   input logic err
);
   assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

   assert_input_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready);

   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);

   assert_err_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!in_ready && !out_valid));
endmodule

bind fdr_run_decoder fdr_run_decoder_chk chk_i (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
   .out_bit(out_bit), .out_ready(out_ready), .err(err)
);

// File: tb/fdr_run_decoder_tb.sv
module fdr_run_decoder_tb_top;
   localparam int MAXG   = 8;
   localparam int NVEC   = 12;
   localparam int WD_CYC = 100000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_mode = 1'b0, in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0;
   logic in_ready, out_valid, out_bit, err;
   logic out_ready = 1'b1;
   logic bp_en = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   int checks = 0, fails = 0;
   logic got[$];

   always #4 clk = ~clk;

   fdr_run_decoder #(.MAX_GROUP(MAXG)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .in_valid(in_valid),
      .in_bit(in_bit), .in_last(in_last), .in_ready(in_ready),
      .out_valid(out_valid), .out_bit(out_bit), .out_ready(out_ready), .err(err)
   );

   always @(posedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready <= bp_en ? lfsr[0] : 1'b1;
   end

   always @(negedge clk) if (out_valid && out_ready) got.push_back(out_bit);

   // {ext, polarity, k[3:0], tail[7:0], last, backpressure}
   localparam logic [15:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 4'd1, 8'd0,   1'b0, 1'b0},  // 00   -> L0
      {1'b0, 1'b0, 4'd2, 8'd0,   1'b0, 1'b0},  // 1000 -> L2
      {1'b0, 1'b0, 4'd2, 8'd2,   1'b0, 1'b0},  // 1010 -> L4
      {1'b0, 1'b0, 4'd3, 8'd5,   1'b0, 1'b1},
      {1'b1, 1'b0, 4'd2, 8'd1,   1'b0, 1'b0},
      {1'b1, 1'b1, 4'd3, 8'd0,   1'b0, 1'b0},
      {1'b0, 1'b0, 4'd1, 8'd1,   1'b0, 1'b0},
      {1'b1, 1'b1, 4'd1, 8'd1,   1'b0, 1'b1},
      {1'b0, 1'b0, 4'd8, 8'd255, 1'b0, 1'b1},
      {1'b1, 1'b1, 4'd4, 8'd3,   1'b1, 1'b0},
      {1'b0, 1'b0, 4'd1, 8'd0,   1'b1, 1'b0},
      {1'b1, 1'b0, 4'd5, 8'd7,   1'b0, 1'b1}
   };

   task automatic send_bit(input logic b, input logic last);
      @(negedge clk);
      in_valid = 1'b1; in_bit = b; in_last = last;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic send_cw(input logic ext, input logic pol, input int k,
                          input int tail, input logic last);
      ext_mode = ext;
      if (ext) send_bit(pol, 1'b0);
      for (int i = 0; i < k - 1; i++) send_bit(1'b1, 1'b0);
      send_bit(1'b0, 1'b0);
      for (int i = k - 1; i >= 0; i--) send_bit(1'((tail >> i) & 1), (i == 0) ? last : 1'b0);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (!(in_ready && !out_valid));
   endtask

   task automatic check(input string req, input logic ok, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   logic done = 1'b0;

   initial begin
      repeat (WD_CYC) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      check("R1 in_ready", in_ready == 1'b1, int'(in_ready), 1);
      check("R1 out_valid", out_valid == 1'b0, int'(out_valid), 0);
      check("R1 err", err == 1'b0, int'(err), 0);

      // Vector table: R2 lengths, R3 normal, R4 extended, R5 last, R7 backpressure, R9 mode switch
      for (int v = 0; v < NVEC; v++) begin
         logic ext, pol, last, bp;
         int k, tail, len, exp_n, mism;
         ext  = VEC[v][15]; pol = VEC[v][14];
         k    = int'(VEC[v][13:10]); tail = int'(VEC[v][9:2]);
         last = VEC[v][1]; bp = VEC[v][0];
         len   = (1 << k) - 2 + tail;
         exp_n = last ? len : len + 1;
         got.delete();
         bp_en = bp;
         send_cw(ext, pol, k, tail, last);
         wait_idle();
         bp_en = 1'b0;
         mism = 0;
         for (int i = 0; i < got.size(); i++) begin
            logic e;
            e = (i < len) ? (ext & pol) : ~(ext & pol);
            if (got[i] !== e) mism++;
         end
         check($sformatf("R2/R3/R4/R5/R9 vec%0d count", v), got.size() == exp_n, got.size(), exp_n);
         check($sformatf("R3/R4/R7 vec%0d bits", v), mism == 0, mism, 0);
      end

      // R8: input stalled while a run plays out
      got.delete();
      send_cw(1'b0, 1'b0, 3, 7, 1'b0);
      @(negedge clk); @(negedge clk);
      check("R8 out_valid during run", out_valid == 1'b1, int'(out_valid), 1);
      check("R8 in_ready during run", in_ready == 1'b0, int'(in_ready), 0);
      wait_idle();
      check("R8 run length 13+1", got.size() == 14, got.size(), 14);

      // R6: prefix of MAX_GROUP ones
      got.delete();
      ext_mode = 1'b0;
      for (int i = 0; i < MAXG; i++) send_bit(1'b1, 1'b0);
      check("R6 err set", err == 1'b1, int'(err), 1);
      check("R6 in_ready low", in_ready == 1'b0, int'(in_ready), 0);
      repeat (5) @(negedge clk);
      check("R6 err sticky", err == 1'b1, int'(err), 1);
      check("R6 no output", got.size() == 0, got.size(), 0);
      do_reset();
      @(negedge clk);
      check("R1 err cleared by reset", err == 1'b0, int'(err), 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule